// File: doc/BRIEF.md
# DMA Page-Extended Address Generator

This block produces the 24-bit physical address for every transfer of one DMA channel. It combines an 8-bit page value with a 16-bit address counter. The 16-bit counter steps once per accepted transfer, and a 16-bit remaining-count register steps down alongside it. The channel runs in one of two widths. In byte width each transfer moves one byte, and the counter addresses bytes inside a 64 KB page. In word width each transfer moves 16 bits, and the counter addresses words inside a 128 KB page.

The counter never carries into the page. A run that passes the top of its page wraps back to the bottom of the same page. Loading the channel captures the page, the width, the start address and the count in one cycle. After the final transfer the block raises `done_o` and refuses further strobes until the next load.

Top module: `dma_paddr_gen`

## Requirements
- R1: While the reset is active, and after it is released, the outputs are `paddr_o` = 0, `byte_en_o` = 2'b01 and `done_o` = 1. In this state transfer strobes are ignored until the first load.
- R2: A cycle with `load_i` high captures `page_i`, `word_mode_i`, `start_addr_i` and `start_cnt_i`, and clears `done_o`. The new values appear on the outputs after that clock edge. A load takes priority over a transfer strobe in the same cycle.
- R3: In byte width (`word_mode_i` = 0 at load), `paddr_o[23:16]` is the page and `paddr_o[15:0]` is the address counter.
- R4: In word width (`word_mode_i` = 1 at load), `paddr_o[23:17]` is page bits [7:1] and `paddr_o[16:1]` is the address counter. `paddr_o[0]` is 0, and page bit 0 has no effect.
- R5: Each accepted transfer adds 1 to the address counter modulo 65536. The page bits of `paddr_o` never change as a result: the counter wraps within the 64 KB page (byte width) or the 128 KB page (word width).
- R6: A loaded count of C gives exactly C+1 accepted transfers. `done_o` rises after the clock edge of the transfer in which the count was 0. A count of 0xFFFF gives 65536 transfers.
- R7: While `done_o` is high, transfer strobes change neither `paddr_o` nor `done_o`.
- R8: `byte_en_o` is 2'b11 in word width. In byte width it is 2'b01 when `paddr_o[0]` is 0 and 2'b10 when `paddr_o[0]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| load_i | input | 1 | Capture the channel setup and restart |
| word_mode_i | input | 1 | Channel width at load: 0 = byte, 1 = word |
| page_i | input | 8 | Page value captured at load |
| start_addr_i | input | 16 | Start value of the address counter |
| start_cnt_i | input | 16 | Number of transfers minus one |
| xfer_i | input | 1 | One transfer completes in this cycle |
| paddr_o | output | 24 | Physical address of the current transfer |
| byte_en_o | output | 2 | Byte lane enables for the current transfer |
| done_o | output | 1 | Terminal count has been reached; idle until reloaded |

## Verification
The assertions assume that `load_i` and `xfer_i` are synchronous to `clk`, and that the channel width is fixed between loads. Under that assumption a change of the page bits or a step of the counter has a single cause. The stimulus changes inputs only on the falling edge. Every setup is presented together with one load pulse, and strobes are given only while the setup inputs are held. The page-wrap, single-transfer and full 65536-transfer cases are run in both widths where the width affects them.

// File: rtl/dma_paddr_pkg.sv
package dma_paddr_pkg;
  typedef enum logic {
    XW_BYTE = 1'b0,
    XW_WORD = 1'b1
  } xfer_width_e;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  input  logic              xfer_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              step;
  logic              en;

  assign step = xfer_i && !done_q && !load_i;
  assign en   = load_i || step;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (load_i) begin
      addr_d = start_addr_i;
      cnt_d  = start_cnt_i;
      done_d = 1'b0;
    end else if (step) begin
      addr_d = addr_q + ADDR_ONE;
      cnt_d  = cnt_q - CNT_ONE;
      done_d = (cnt_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;
endmodule

// File: rtl/dma_paddr_map.sv
module dma_paddr_map
  import dma_paddr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int LANES  = 2
) (
  input  xfer_width_e                width_i,
  input  logic [PAGE_W-1:0]          page_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic [PAGE_W+ADDR_W-1:0]   paddr_o,
  output logic [LANES-1:0]           byte_en_o
);
  localparam int PADDR_W = PAGE_W + ADDR_W;

  logic [PADDR_W-1:0] byte_addr;
  logic [PADDR_W-1:0] word_addr;

  assign byte_addr = {page_i, addr_i};
  assign word_addr = {page_i[PAGE_W-1:1], addr_i, 1'b0};
  assign paddr_o   = (width_i == XW_WORD) ? word_addr : byte_addr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byte_en_o[g] = (width_i == XW_WORD) ||
                          (32'(byte_addr[0]) == g);
  end
endmodule

// File: rtl/dma_paddr_gen.sv
module dma_paddr_gen
  import dma_paddr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       word_mode_i,
  input  logic [PAGE_W-1:0]          page_i,
  input  logic [ADDR_W-1:0]          start_addr_i,
  input  logic [CNT_W-1:0]           start_cnt_i,
  input  logic                       xfer_i,
  output logic [PAGE_W+ADDR_W-1:0]   paddr_o,
  output logic [1:0]                 byte_en_o,
  output logic                       done_o
);
  localparam int PADDR_W = PAGE_W + ADDR_W;

  logic              rst_sync_n;
  logic [PAGE_W-1:0] page_q, page_d;
  xfer_width_e       width_q, width_d;
  logic [ADDR_W-1:0] addr;

  dma_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    page_d  = page_i;
    width_d = word_mode_i ? XW_WORD : XW_BYTE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      page_q  <= '0;
      width_q <= XW_BYTE;
    end else if (load_i) begin
      page_q  <= page_d;
      width_q <= width_d;
    end
  end

  dma_xfer_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .start_cnt_i  (start_cnt_i),
    .xfer_i       (xfer_i),
    .addr_o       (addr),
    .done_o       (done_o)
  );

  dma_paddr_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LANES(2)) u_map (
    .width_i   (width_q),
    .page_i    (page_q),
    .addr_i    (addr),
    .paddr_o   (paddr_o),
    .byte_en_o (byte_en_o)
  );
endmodule

// File: rtl/dma_paddr_gen_chk.sv
module dma_paddr_gen_chk #(
  parameter int ADDR_W  = 16,
  parameter int PADDR_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_i,
  input logic               xfer_i,
  input logic [PADDR_W-1:0] paddr_o,
  input logic [1:0]         byte_en_o,
  input logic               done_o
);
  // R5: page bits of the address move only on a load
  a_r5_no_page_carry: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> paddr_o[PADDR_W-1:ADDR_W+1] == $past(paddr_o[PADDR_W-1:ADDR_W+1]));

  // R5: byte-width step is +1 on the low 16 bits
  a_r5_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && !done_o && !load_i && byte_en_o != 2'b11) |=>
      paddr_o[ADDR_W-1:0] == $past(paddr_o[ADDR_W-1:0]) + ADDR_W'(1));

  // R4: word width keeps address bit 0 low
  a_r4_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en_o == 2'b11 |-> !paddr_o[0]);

  // R8: byte width selects exactly the lane of address bit 0
  a_r8_lane_select: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en_o != 2'b11 |-> ($onehot(byte_en_o) && byte_en_o[1] == paddr_o[0]));

  // R7: nothing moves after terminal count without a load
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> (done_o && $stable(paddr_o)));

  // R2: a load always restarts the channel
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !done_o);
endmodule

bind dma_paddr_gen dma_paddr_gen_chk #(.ADDR_W(ADDR_W), .PADDR_W(PADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .load_i    (load_i),
  .xfer_i    (xfer_i),
  .paddr_o   (paddr_o),
  .byte_en_o (byte_en_o),
  .done_o    (done_o)
);

// File: tb/dma_paddr_gen_tb.sv
module dma_paddr_gen_tb;
  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic        word_mode_i;
  logic [7:0]  page_i;
  logic [15:0] start_addr_i;
  logic [15:0] start_cnt_i;
  logic        xfer_i;
  logic [23:0] paddr_o;
  logic [1:0]  byte_en_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  dma_paddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .word_mode_i(word_mode_i),
    .page_i(page_i), .start_addr_i(start_addr_i), .start_cnt_i(start_cnt_i),
    .xfer_i(xfer_i), .paddr_o(paddr_o), .byte_en_o(byte_en_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  // word, page, addr, count, strobes, expected paddr, byte enables, done
  localparam int VW = 1 + 8 + 16 + 16 + 8 + 24 + 2 + 1;
  localparam int NV = 10;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 8'h12, 16'h3400, 16'h0005, 8'd0, 24'h123400, 2'b01, 1'b0},
    {1'b0, 8'h12, 16'h3400, 16'h0005, 8'd3, 24'h123403, 2'b10, 1'b0},
    {1'b0, 8'hA5, 16'hFFFE, 16'h0003, 8'd3, 24'hA50001, 2'b10, 1'b0},
    {1'b0, 8'h01, 16'h0010, 16'h0002, 8'd3, 24'h010013, 2'b10, 1'b1},
    {1'b0, 8'h01, 16'h0010, 16'h0002, 8'd6, 24'h010013, 2'b10, 1'b1},
    {1'b1, 8'h35, 16'h1234, 16'h000A, 8'd0, 24'h342468, 2'b11, 1'b0},
    {1'b1, 8'h35, 16'h1234, 16'h000A, 8'd2, 24'h34246C, 2'b11, 1'b0},
    {1'b1, 8'h80, 16'hFFFF, 16'h0001, 8'd1, 24'h800000, 2'b11, 1'b0},
    {1'b1, 8'h80, 16'hFFFF, 16'h0000, 8'd1, 24'h800000, 2'b11, 1'b1},
    {1'b0, 8'hFF, 16'hFFFF, 16'h0000, 8'd1, 24'hFF0000, 2'b01, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic w, input logic [7:0] pg,
                         input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    word_mode_i = w; page_i = pg; start_addr_i = a; start_cnt_i = c; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_xfer(input int n);
    repeat (n) begin
      @(negedge clk);
      xfer_i = 1'b1;
    end
    @(negedge clk);
    xfer_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; load_i = 1'b0; xfer_i = 1'b0; word_mode_i = 1'b0;
    page_i = '0; start_addr_i = '0; start_cnt_i = '0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1 paddr in reset", 32'(paddr_o), 32'h0);
    chk("R1 done in reset", 32'(done_o), 32'h1);
    chk("R1 byte_en in reset", 32'(byte_en_o), 32'h1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: strobes before the first load are ignored
    do_xfer(3);
    chk("R1 paddr idle after reset", 32'(paddr_o), 32'h0);
    chk("R1 done idle after reset", 32'(done_o), 32'h1);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      do_load(v[75], v[74:67], v[66:51], v[50:35]);
      do_xfer(int'(v[34:27]));
      chk($sformatf("R3/R4/R5 vec %0d paddr", i), 32'(paddr_o), 32'(v[26:3]));
      chk($sformatf("R8 vec %0d byte_en", i), 32'(byte_en_o), 32'(v[2:1]));
      chk($sformatf("R6/R7 vec %0d done", i), 32'(done_o), 32'(v[0]));
    end

    // R4: page bit 0 has no effect in word width
    do_load(1'b1, 8'h34, 16'h1234, 16'h0003);
    chk("R4 page bit0 ignored", 32'(paddr_o), 32'h342468);

    // R2: load wins over a simultaneous strobe, and clears done
    do_load(1'b0, 8'h01, 16'h0000, 16'h0000);
    do_xfer(1);
    chk("R6 done after one", 32'(done_o), 32'h1);
    @(negedge clk);
    word_mode_i = 1'b0; page_i = 8'h22; start_addr_i = 16'h5555;
    start_cnt_i = 16'h0004; load_i = 1'b1; xfer_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; xfer_i = 1'b0;
    chk("R2 load priority paddr", 32'(paddr_o), 32'h225555);
    chk("R2 load clears done", 32'(done_o), 32'h0);

    // R6: full count of 0xFFFF yields 65536 transfers, wrapping in page
    do_load(1'b0, 8'h07, 16'h8000, 16'hFFFF);
    do_xfer(65535);
    chk("R6 full count not yet done", 32'(done_o), 32'h0);
    chk("R5 full count paddr", 32'(paddr_o), 32'h077FFF);
    do_xfer(1);
    chk("R6 full count done", 32'(done_o), 32'h1);
    chk("R5 full count wrapped in page", 32'(paddr_o), 32'h078000);

    // R1: asynchronous reset in the middle of a run
    do_load(1'b1, 8'h44, 16'h0100, 16'h0010);
    do_xfer(2);
    @(negedge clk);
    rst_n = 1'b0;
    #1ns;
    chk("R1 async reset paddr", 32'(paddr_o), 32'h0);
    chk("R1 async reset done", 32'(done_o), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule